// File: doc/BRIEF.md
# Alignment-Aware ISA and Exception-PC Register Unit

This block holds the machine ISA register and the three exception-PC registers (machine, supervisor and debug) of a RISC-V style core. It also derives the instruction-address alignment mask from the compressed-instruction enable bit (bit 2, C) of the ISA register. Software reads and writes these registers through a single address/data port. The core supplies its current PC with every request, so the unit can refuse an ISA write that would leave that PC misaligned.

The alignment mask goes to the fetch and redirect logic. Every redirect target is passed through it, and a candidate PC that has a bit set outside the mask raises a misaligned flag. When C is disabled, reads of the exception-PC registers hide bit 1. The stored values keep that bit, so turning C back on shows it again. Because ISA writes that would misalign the PC are refused, and every redirect target is masked, the PC cannot become misaligned, and fetch needs no alignment check of its own.

Top module: `pcal_csr_unit`

## Requirements
- R1: After synchronous reset, the ISA register reads as the reset parameter (default: MXL=2 in bits 63:62, with the A, C, D, F, I, M, S and U bits set), all three exception-PC registers read zero, and the alignment mask is all ones.
- R2: The alignment mask is all ones while ISA bit 2 (C) is set. While C is clear, the mask equals all ones with only bit 1 cleared.
- R3: A write to the ISA register (address 0x301) is discarded completely, with no bit changed, when the written value has bit 2 clear and bit 1 of the current PC is set.
- R4: When an ISA write is accepted and the written bit 5 (F) is clear, bit 3 (D) is stored as zero whatever value was written for it.
- R5: The MXL field (the top two bits) keeps its reset value regardless of what is written. Bits 26 up to XLEN-3 of the ISA register always read zero. Bits 25:0 take the written value, subject to R3 and R4.
- R6: Reads of the machine (0x341), supervisor (0x141) and debug (0x7B1) exception-PC registers return the stored value ANDed with the alignment mask. The stored bit 1 is kept, so it reads back again once C is re-enabled.
- R7: Bit 0 of every exception-PC register is stored as zero and always reads as zero.
- R8: The redirect output equals the redirect target ANDed with the alignment mask.
- R9: The misaligned flag is high exactly when the candidate PC has a bit set where the alignment mask is zero, that is, bit 1 is set while C is off.
- R10: A write changes the register at the next rising clock edge. Before that edge the read data shows the old value, because read data is combinational from the current state. Exception-PC writes are accepted whatever the current PC.
- R11: A read of any other address returns zero, and a write to it changes none of the four registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe for the addressed register |
| csr_addr | input | 12 | Register address for both read and write |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data, masked as required |
| cur_pc | input | XLEN | PC of the instruction issuing the access |
| redir_target | input | XLEN | Raw target of a serializing redirect |
| redir_pc | output | XLEN | Redirect target after the alignment mask |
| cand_pc | input | XLEN | Candidate PC to test for misalignment |
| pc_misaligned | output | 1 | Candidate PC has a bit set outside the mask |
| align_mask | output | XLEN | Current instruction-address alignment mask |

## Verification
Two functions can act in the same cycle: an ISA write that clears C, and the check of the current PC that may veto that write. The veto reads the PC bit in the very cycle of the write. The bench drives ISA writes with random values together with random PCs whose bit 1 is set about half of the time. A reference model then predicts whether the write stands, and the bench judges the result through the ISA read-back, the alignment mask and the masked exception-PC reads in the following cycle. A second overlap is also exercised: the same exception-PC register is read while it is being written, and the bench confirms that the old value is still visible until the clock edge.

// File: rtl/pcal_pkg.sv
package pcal_pkg;

    // Register addresses (decoded by software, so fixed)
    localparam logic [11:0] ADDR_ISA  = 12'h301;
    localparam logic [11:0] ADDR_MEPC = 12'h341;
    localparam logic [11:0] ADDR_SEPC = 12'h141;
    localparam logic [11:0] ADDR_DPC  = 12'h7B1;

    // ISA extension bit positions
    localparam int unsigned EXT_W  = 26;
    localparam int unsigned BIT_C  = 2;
    localparam int unsigned BIT_D  = 3;
    localparam int unsigned BIT_F  = 5;
    localparam int unsigned MXL_W  = 2;

    // Exception-PC slots
    localparam int unsigned NUM_EPC = 3;
    typedef enum logic [1:0] {
        SLOT_M = 2'd0,
        SLOT_S = 2'd1,
        SLOT_D = 2'd2
    } epc_slot_e;

    typedef struct packed {
        logic                isa;
        logic [NUM_EPC-1:0]  epc;
    } csr_sel_t;

    function automatic csr_sel_t decode_addr(input logic [11:0] a);
        csr_sel_t s;
        s = '0;
        unique case (a)
            ADDR_ISA:  s.isa = 1'b1;
            ADDR_MEPC: s.epc[SLOT_M] = 1'b1;
            ADDR_SEPC: s.epc[SLOT_S] = 1'b1;
            ADDR_DPC:  s.epc[SLOT_D] = 1'b1;
            default:   s = '0;
        endcase
        return s;
    endfunction

    // D depends on F: drop D when F is absent
    function automatic logic [EXT_W-1:0] legalize_ext(input logic [EXT_W-1:0] v);
        logic [EXT_W-1:0] r;
        r = v;
        if (!v[BIT_F]) r[BIT_D] = 1'b0;
        return r;
    endfunction

    // Write would leave a 2-byte aligned PC misaligned
    function automatic logic isa_write_refused(input logic new_c, input logic pc_b1);
        return !new_c && pc_b1;
    endfunction

endpackage

// File: rtl/pcal_isa_reg.sv
module pcal_isa_reg
    import pcal_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter logic [XLEN-1:0] RESET_VAL = {2'b10, {(XLEN-28){1'b0}}, 26'h014112D}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [XLEN-1:0]  wdata,
    input  logic             pc_b1,
    output logic [XLEN-1:0]  isa_val,
    output logic             c_en
);

    localparam int unsigned GAP_W = XLEN - MXL_W - EXT_W;

    logic [EXT_W-1:0] ext_q;
    logic [EXT_W-1:0] ext_d;
    logic             accept;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[XLEN-1:EXT_W];

    assign accept = wr_en && !isa_write_refused(wdata[BIT_C], pc_b1);
    assign ext_d  = legalize_ext(wdata[EXT_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= RESET_VAL[EXT_W-1:0];
        end else if (accept) begin
            ext_q <= ext_d;
        end
    end

    assign isa_val = {RESET_VAL[XLEN-1 -: MXL_W], {GAP_W{1'b0}}, ext_q};
    assign c_en    = ext_q[BIT_C];

    // R3: a refused write leaves every stored bit untouched
    a_r3_refused_write_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wdata[BIT_C] && pc_b1) |=> $stable(ext_q));

    // R4: accepted write with F clear stores D clear
    a_r4_d_follows_f: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !pc_b1 && !wdata[BIT_F]) |=> !ext_q[BIT_D]);

    // R3: C can only fall when the PC was 4-byte aligned at the write
    a_r3_c_fall_aligned: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pc_b1) |=> !$fell(ext_q[BIT_C]));

endmodule

// File: rtl/pcal_epc_bank.sv
module pcal_epc_bank
    import pcal_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned COUNT = NUM_EPC
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [COUNT-1:0]            wr_sel,
    input  logic [XLEN-1:0]             wdata,
    input  logic [XLEN-1:0]             mask,
    output logic [COUNT-1:0][XLEN-1:0]  rd_val
);

    logic [COUNT-1:0][XLEN-1:0] epc_q;

    for (genvar i = 0; i < COUNT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                epc_q[i] <= '0;
            end else if (wr_sel[i]) begin
                epc_q[i] <= {wdata[XLEN-1:1], 1'b0};
            end
        end

        assign rd_val[i] = epc_q[i] & mask;

        // R6: storage is only changed by its own write, never by the mask
        a_r6_epc_hold: assert property (@(posedge clk) disable iff (rst)
            !wr_sel[i] |=> $stable(epc_q[i]));

        // R6: bit 1 can only be hidden in the read path when the mask clears it
        a_r6_bit1_hidden_only_by_mask: assert property (@(posedge clk) disable iff (rst)
            (epc_q[i][1] && !rd_val[i][1]) |-> !mask[1]);

        // R10: a write lands on the next edge
        a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
            wr_sel[i] |=> (epc_q[i][XLEN-1:1] == $past(wdata[XLEN-1:1])));
    end

endmodule

// File: rtl/pcal_align.sv
module pcal_align
    import pcal_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             c_en,
    input  logic [XLEN-1:0]  redir_target,
    input  logic [XLEN-1:0]  cand_pc,
    output logic [XLEN-1:0]  mask,
    output logic [XLEN-1:0]  redir_pc,
    output logic             misaligned
);

    localparam logic [XLEN-1:0] HALF_BIT = XLEN'(2);

    always_comb begin
        mask = '1;
        if (!c_en) mask = ~HALF_BIT;
    end

    assign redir_pc   = redir_target & mask;
    assign misaligned = |(cand_pc & ~mask);

    // R2: mask shape follows C
    a_r2_mask_shape: assert property (@(posedge clk) disable iff (rst)
        (c_en ? (&mask) : ($countones(~mask) == 1 && !mask[1])));

    // R8: redirect never carries bit 1 while C is off
    a_r8_redirect_bit1: assert property (@(posedge clk) disable iff (rst)
        redir_pc[1] |-> c_en);

    // R9: flag only when C is off and the candidate has bit 1 set
    a_r9_flag_cause: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> (!c_en && cand_pc[1]));

endmodule

// File: rtl/pcal_csr_unit.sv
module pcal_csr_unit
    import pcal_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter logic [XLEN-1:0] ISA_RESET = {2'b10, {(XLEN-28){1'b0}}, 26'h014112D}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_we,
    input  logic [11:0]      csr_addr,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  redir_target,
    output logic [XLEN-1:0]  redir_pc,
    input  logic [XLEN-1:0]  cand_pc,
    output logic             pc_misaligned,
    output logic [XLEN-1:0]  align_mask
);

    csr_sel_t                     sel;
    logic [XLEN-1:0]              isa_val;
    logic                         c_en;
    logic [NUM_EPC-1:0][XLEN-1:0] epc_rd;
    logic [NUM_EPC-1:0]           epc_wr;
    logic                         unused_pc_bits;

    assign unused_pc_bits = ^{cur_pc[XLEN-1:2], cur_pc[0]};

    assign sel    = decode_addr(csr_addr);
    assign epc_wr = sel.epc & {NUM_EPC{csr_we}};

    pcal_isa_reg #(
        .XLEN      (XLEN),
        .RESET_VAL (ISA_RESET)
    ) isa_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (csr_we && sel.isa),
        .wdata   (csr_wdata),
        .pc_b1   (cur_pc[1]),
        .isa_val (isa_val),
        .c_en    (c_en)
    );

    pcal_align #(
        .XLEN (XLEN)
    ) align_i (
        .clk          (clk),
        .rst          (rst),
        .c_en         (c_en),
        .redir_target (redir_target),
        .cand_pc      (cand_pc),
        .mask         (align_mask),
        .redir_pc     (redir_pc),
        .misaligned   (pc_misaligned)
    );

    pcal_epc_bank #(
        .XLEN  (XLEN),
        .COUNT (NUM_EPC)
    ) epc_i (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (epc_wr),
        .wdata  (csr_wdata),
        .mask   (align_mask),
        .rd_val (epc_rd)
    );

    always_comb begin
        csr_rdata = '0;
        if (sel.isa) csr_rdata = isa_val;
        for (int i = 0; i < NUM_EPC; i++) begin
            if (sel.epc[i]) csr_rdata = epc_rd[i];
        end
    end

    // R7: exception-PC reads never show bit 0
    a_r7_epc_bit0_zero: assert property (@(posedge clk) disable iff (rst)
        (|sel.epc) |-> !csr_rdata[0]);

    // R11: unmapped addresses read zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (!sel.isa && !(|sel.epc)) |-> (csr_rdata == '0));

endmodule

// File: tb/pcal_csr_unit_tb.sv
module pcal_csr_unit_tb_top;

    localparam int XLEN = 64;
    localparam logic [11:0] A_ISA  = 12'h301;
    localparam logic [11:0] A_MEPC = 12'h341;
    localparam logic [11:0] A_SEPC = 12'h141;
    localparam logic [11:0] A_DPC  = 12'h7B1;
    localparam logic [11:0] A_NONE = 12'h340;

    logic            clk = 1'b0;
    logic            rst;
    logic            csr_we;
    logic [11:0]     csr_addr;
    logic [XLEN-1:0] csr_wdata;
    logic [XLEN-1:0] csr_rdata;
    logic [XLEN-1:0] cur_pc;
    logic [XLEN-1:0] redir_target;
    logic [XLEN-1:0] redir_pc;
    logic [XLEN-1:0] cand_pc;
    logic            pc_misaligned;
    logic [XLEN-1:0] align_mask;

    int total = 0;
    int bad   = 0;

    logic [25:0]     m_ext;
    logic [XLEN-1:0] m_epc [3];

    always #5 clk = ~clk;

    pcal_csr_unit dut_i (
        .clk           (clk),
        .rst           (rst),
        .csr_we        (csr_we),
        .csr_addr      (csr_addr),
        .csr_wdata     (csr_wdata),
        .csr_rdata     (csr_rdata),
        .cur_pc        (cur_pc),
        .redir_target  (redir_target),
        .redir_pc      (redir_pc),
        .cand_pc       (cand_pc),
        .pc_misaligned (pc_misaligned),
        .align_mask    (align_mask)
    );

    function automatic logic [XLEN-1:0] exp_mask();
        return m_ext[2] ? '1 : ~64'h2;
    endfunction

    function automatic logic [XLEN-1:0] exp_isa();
        return {2'b10, 36'd0, m_ext};
    endfunction

    function automatic logic [XLEN-1:0] exp_read(input logic [11:0] a);
        case (a)
            A_ISA:   return exp_isa();
            A_MEPC:  return m_epc[0] & exp_mask();
            A_SEPC:  return m_epc[1] & exp_mask();
            A_DPC:   return m_epc[2] & exp_mask();
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [11:0] a, input logic [XLEN-1:0] d, input logic [XLEN-1:0] pc);
        logic [25:0] v;
        case (a)
            A_ISA: begin
                if (!(!d[2] && pc[1])) begin
                    v = d[25:0];
                    if (!v[5]) v[3] = 1'b0;
                    m_ext = v;
                end
            end
            A_MEPC: m_epc[0] = {d[XLEN-1:1], 1'b0};
            A_SEPC: m_epc[1] = {d[XLEN-1:1], 1'b0};
            A_DPC:  m_epc[2] = {d[XLEN-1:1], 1'b0};
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [11:0] a, input logic [XLEN-1:0] d, input logic [XLEN-1:0] pc);
        @(negedge clk);
        csr_we    = 1'b1;
        csr_addr  = a;
        csr_wdata = d;
        cur_pc    = pc;
        @(posedge clk);
        #1;
        csr_we = 1'b0;
        model_write(a, d, pc);
    endtask

    task automatic read_chk(input string tag, input logic [11:0] a);
        csr_addr = a;
        #1;
        chk(tag, csr_rdata, exp_read(a));
    endtask

    task automatic check_all(input string tag);
        logic [XLEN-1:0] t;
        logic [XLEN-1:0] c;
        read_chk({tag, " R5 isa"}, A_ISA);
        read_chk({tag, " R6 mepc"}, A_MEPC);
        read_chk({tag, " R6 sepc"}, A_SEPC);
        read_chk({tag, " R6 dpc"}, A_DPC);
        t = {$urandom, $urandom};
        c = {$urandom, $urandom};
        redir_target = t;
        cand_pc = c;
        #1;
        chk({tag, " R2 mask"}, align_mask, exp_mask());
        chk({tag, " R8 redirect"}, redir_pc, t & exp_mask());
        chk({tag, " R9 flag"}, {63'd0, pc_misaligned}, {63'd0, (c[1] && !m_ext[2])});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        csr_we = 1'b0;
        csr_addr = A_NONE;
        csr_wdata = '0;
        cur_pc = '0;
        redir_target = '0;
        cand_pc = '0;
        m_ext = 26'h014112D;
        for (int i = 0; i < 3; i++) m_epc[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        read_chk("R1 reset isa", A_ISA);
        chk("R1 reset isa literal", csr_rdata, 64'h8000_0000_0014_112D);
        read_chk("R1 reset mepc", A_MEPC);
        read_chk("R1 reset dpc", A_DPC);
        chk("R1 reset mask", align_mask, '1);

        // R7: bit 0 dropped, bit 1 kept while C on
        do_write(A_MEPC, 64'h0000_1234_5678_9ABF, 64'h2);
        read_chk("R7 mepc bit0", A_MEPC);
        chk("R7 mepc literal", csr_rdata, 64'h0000_1234_5678_9ABE);
        do_write(A_SEPC, 64'h3, 64'h0);
        do_write(A_DPC, 64'hFFFF_0000_0000_0007, 64'h6);

        // R3: clearing C with PC bit 1 set is refused, F/D change also lost
        do_write(A_ISA, 64'h0, 64'h1002);
        check_all("R3 refused");
        chk("R3 isa unchanged", exp_read(A_ISA), 64'h8000_0000_0014_112D);

        // R10: old value visible before the edge
        @(negedge clk);
        csr_we = 1'b1;
        csr_addr = A_SEPC;
        csr_wdata = 64'hABC0;
        cur_pc = 64'h2;
        #1;
        chk("R10 before edge", csr_rdata, 64'h2);
        @(posedge clk);
        #1;
        csr_we = 1'b0;
        model_write(A_SEPC, 64'hABC0, 64'h2);
        read_chk("R10 after edge", A_SEPC);

        // R2/R6: clearing C with aligned PC is accepted; bit 1 hidden
        do_write(A_SEPC, 64'h3, 64'h0);
        do_write(A_ISA, 64'h8000_0000_0014_112D & ~64'h4, 64'h1000);
        check_all("R6 C off");
        chk("R6 mepc hidden", exp_read(A_MEPC), 64'h0000_1234_5678_9ABC);
        chk("R2 mask literal", align_mask, 64'hFFFF_FFFF_FFFF_FFFD);
        cand_pc = 64'h8000_0002;
        #1;
        chk("R9 flag set", {63'd0, pc_misaligned}, 64'd1);
        cand_pc = 64'h8000_0004;
        #1;
        chk("R9 flag clear", {63'd0, pc_misaligned}, 64'd0);

        // R10: exception-PC write accepted with misaligned current PC
        do_write(A_DPC, 64'h46, 64'h2);
        read_chk("R10 dpc any pc", A_DPC);

        // R6: re-enable C shows bit 1 again
        do_write(A_ISA, 64'h0000_0000_0014_112D, 64'h2);
        read_chk("R6 sepc bit1 back", A_SEPC);
        chk("R6 sepc literal", csr_rdata, 64'h2);

        // R4: F clear drops D
        do_write(A_ISA, 64'h000C, 64'h0);
        read_chk("R4 d dropped", A_ISA);
        chk("R4 literal", csr_rdata, 64'h8000_0000_0000_0004);

        // R5: MXL and gap bits ignore writes
        do_write(A_ISA, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0);
        read_chk("R5 mxl fixed", A_ISA);
        chk("R5 literal", csr_rdata, 64'h8000_0000_03FF_FFFF);

        // R11: unmapped address
        do_write(A_NONE, 64'hDEAD_BEEF, 64'h0);
        read_chk("R11 unmapped read", A_NONE);
        check_all("R11 no side effect");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int kind;
            logic [11:0] a;
            logic [XLEN-1:0] d;
            logic [XLEN-1:0] pc;
            kind = int'($urandom % 6);
            case (kind)
                0, 1: a = A_ISA;
                2: a = A_MEPC;
                3: a = A_SEPC;
                4: a = A_DPC;
                default: a = A_NONE;
            endcase
            d = {$urandom, $urandom};
            if (a == A_ISA && ($urandom % 2) == 0) d[2] = 1'b0;
            pc = {$urandom, $urandom};
            pc[0] = 1'b0;
            do_write(a, d, pc);
            check_all("R3 R4 R6 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule